// File: doc/BRIEF.md
# Circular Command Buffer Pointer Controller

This block keeps the bookkeeping for a circular command buffer held in memory. A processor fills the buffer in fixed 32-byte bursts and a graphics engine drains it. The block holds the base and end addresses, the write and read pointers, a count of bytes in flight, two watermark thresholds and a breakpoint address. From these it derives overflow, underflow and breakpoint flags, idle indications and one level interrupt. It moves no data itself: the burst strobe and the drain strobe only say that a transfer happened.

Software reaches the block through a small 16-bit register port. Each 26-bit address quantity is split into a low half and a high half. A write to a low half clears the five alignment bits. A write to a high half keeps only its ten valid bits. The block also offers a control register, a read-only status register and a read-only span value computed from the pointers. Read data is registered and appears one clock after a read strobe.

The interrupt comes from a two-state machine. `IRQ_QUIET` is the reset state. The transition `RAISE` goes from `IRQ_QUIET` to `IRQ_RAISED` when read enable is set and an enabled cause is active. The transition `DROP` goes from `IRQ_RAISED` back to `IRQ_QUIET` when that condition is gone. Each state otherwise holds.

Top module: `cmdring_ctrl`

## Requirements
- R1: After reset every address field, the byte count and the control register read as zero, the interrupt is low, and status reads 0x000C. Status bits are: 0 overflow, 1 underflow, 2 read-idle, 3 command-idle, 4 breakpoint.
- R2: A burst strobe with link enable (control bit 4) set reloads the write pointer from base when it equals end. Otherwise it adds 32 to the write pointer.
- R3: A burst strobe with link enable clear leaves the write pointer and the byte count unchanged.
- R4: A linked burst adds 32 to the byte count. A drain strobe subtracts its byte count and moves the read pointer by the same wrap rule as the write pointer. A burst and a drain in the same cycle apply both changes.
- R5: The span value (addresses 18/19) is write minus read when the write pointer is at or above the read pointer. Otherwise it is end minus read plus write minus base plus 32.
- R6: The overflow flag means the byte count is strictly above the high watermark. The underflow flag means it is strictly below the low watermark. Both appear in status one clock after their inputs change.
- R7: With breakpoint enable (control bit 1) set, the breakpoint flag is set exactly when the read pointer equals the breakpoint address. With it clear, the flag is 0.
- R8: The interrupt is high one clock after the flags when read enable (bit 0) is set and at least one enabled cause is active. The causes are breakpoint (enable bit 5), overflow (bit 2) and underflow (bit 3).
- R9: Read-idle is set when the byte count is zero or the pointers are equal. Command-idle is set when the count is zero, the breakpoint flag is set, or read enable is clear.
- R10: Low halves are at even addresses 2..16 and high halves at the odd address above each. The fields in order are base, end, high watermark, low watermark, byte count, write pointer, read pointer and breakpoint. A low-half write keeps bits 15:5 and a high-half write keeps bits 9:0.
- R11: Writes to the status register (address 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_i | input | 1 | One 32-byte processor burst was written |
| drain_i | input | 1 | The engine consumed drain_bytes_i bytes |
| drain_bytes_i | input | 16 | Byte count of the drain |
| reg_we_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data, valid one clock after the read strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume three things about the inputs. No register write targets the write pointer or the byte count in a cycle that also carries a strobe. A drain never removes more bytes than are counted. Drain counts are multiples of 32, so the pointers stay aligned. The stimulus issues register accesses and strobes in separate cycles and drains only in 32-byte steps. It also waits for the flag and interrupt stages to settle before it samples anything.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int LO_W   = 16;
    localparam int ADDR_W = 5;
    localparam int NF     = 8;

    localparam int F_BASE = 0;
    localparam int F_END  = 1;
    localparam int F_HIWM = 2;
    localparam int F_LOWM = 3;
    localparam int F_DIST = 4;
    localparam int F_WPTR = 5;
    localparam int F_RPTR = 6;
    localparam int F_BKPT = 7;

    localparam logic [ADDR_W-1:0] A_STATUS  = 5'd0;
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd1;
    localparam logic [ADDR_W-1:0] A_SPAN_LO = 5'd18;
    localparam logic [ADDR_W-1:0] A_SPAN_HI = 5'd19;

    typedef struct packed {
        logic bp_ie;
        logic link_en;
        logic unf_ie;
        logic ovf_ie;
        logic bp_en;
        logic rd_en;
    } ctrl_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic logic [ADDR_W-1:0] lo_addr(input int f);
        return ADDR_W'(2 + 2 * f);
    endfunction

endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int HI_BITS     = 10,
    parameter int CNT_W       = 16,
    parameter int BURST_BYTES = 32,
    localparam int AW         = LO_W + HI_BITS,
    localparam int ALIGN      = $clog2(BURST_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   burst_i,
    input  logic                   drain_i,
    input  logic [CNT_W-1:0]       drain_bytes_i,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [LO_W-1:0]        wdata_i,
    output ctrl_t                  ctrl_o,
    output logic [NF-1:0][AW-1:0]  fld_o
);

    ctrl_t         ctrl_q;
    logic [AW-1:0] fld [NF];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we_i && addr_i == A_CTRL) begin
            ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
        end
    end

    assign ctrl_o = ctrl_q;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam logic [ADDR_W-1:0] LO_A = lo_addr(i);
        localparam logic [ADDR_W-1:0] HI_A = lo_addr(i) + 5'd1;

        logic [AW-1:0] q;
        logic [AW-1:0] nxt;
        logic          wr_lo;
        logic          wr_hi;

        assign wr_lo = we_i && (addr_i == LO_A);
        assign wr_hi = we_i && (addr_i == HI_A);

        if (i == F_WPTR) begin : g_wptr
            always_comb begin
                nxt = q;
                if (burst_i && ctrl_q.link_en) begin
                    nxt = (q == fld[F_END]) ? fld[F_BASE] : q + AW'(BURST_BYTES);
                end
            end
        end else if (i == F_RPTR) begin : g_rptr
            always_comb begin
                nxt = q;
                if (drain_i) begin
                    nxt = (q == fld[F_END]) ? fld[F_BASE] : q + AW'(drain_bytes_i);
                end
            end
        end else if (i == F_DIST) begin : g_dist
            always_comb begin
                nxt = q;
                if (burst_i && ctrl_q.link_en) begin
                    nxt = nxt + AW'(BURST_BYTES);
                end
                if (drain_i) begin
                    nxt = nxt - AW'(drain_bytes_i);
                end
            end
        end else begin : g_plain
            assign nxt = q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_lo) begin
                q <= {q[AW-1:LO_W], wdata_i[LO_W-1:ALIGN], {ALIGN{1'b0}}};
            end else if (wr_hi) begin
                q <= {wdata_i[HI_BITS-1:0], q[LO_W-1:0]};
            end else begin
                q <= nxt;
            end
        end

        assign fld[i]   = q;
        assign fld_o[i] = q;
    end

    logic wp_touch;
    logic cnt_touch;
    assign wp_touch  = we_i && (addr_i == lo_addr(F_WPTR) || addr_i == lo_addr(F_WPTR) + 5'd1);
    assign cnt_touch = we_i && (addr_i == lo_addr(F_DIST) || addr_i == lo_addr(F_DIST) + 5'd1);

    // R2: a linked burst at the end address reloads the write pointer from base
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_i && ctrl_q.link_en && !wp_touch && fld[F_WPTR] == fld[F_END])
        |=> fld[F_WPTR] == $past(fld[F_BASE]));

    // R3: an unlinked burst moves nothing
    assert_unlinked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_i && !ctrl_q.link_en && !drain_i && !wp_touch && !cnt_touch)
        |=> $stable(fld[F_WPTR]) && $stable(fld[F_DIST]));

endmodule

// File: rtl/cmdring_flags.sv
module cmdring_flags
    import cmdring_pkg::*;
#(
    parameter int HI_BITS = 10,
    localparam int AW     = LO_W + HI_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic          bp_en_i,
    input  logic [AW-1:0] dist_i,
    input  logic [AW-1:0] hiwm_i,
    input  logic [AW-1:0] lowm_i,
    input  logic [AW-1:0] wptr_i,
    input  logic [AW-1:0] rptr_i,
    input  logic [AW-1:0] bkpt_i,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          bp_o,
    output logic          read_idle_o,
    output logic          cmd_idle_o
);

    logic bp_hit;
    logic empty;

    assign bp_hit = bp_en_i && (rptr_i == bkpt_i);
    assign empty  = (dist_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_o       <= 1'b0;
            unf_o       <= 1'b0;
            bp_o        <= 1'b0;
            read_idle_o <= 1'b1;
            cmd_idle_o  <= 1'b1;
        end else begin
            ovf_o       <= dist_i > hiwm_i;
            unf_o       <= dist_i < lowm_i;
            bp_o        <= bp_hit;
            read_idle_o <= empty || (rptr_i == wptr_i);
            cmd_idle_o  <= empty || bp_hit || !rd_en_i;
        end
    end

    // R7: breakpoint flag is forced low while its enable is clear
    assert_bp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_en_i |=> !bp_o);

    // R6: no overflow flag while the count is at or below the high mark
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_i <= hiwm_i) |=> !ovf_o);

    // R9: an empty buffer reports both idle bits
    assert_empty_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> read_idle_o && cmd_idle_o);

endmodule

// File: rtl/cmdring_irq.sv
module cmdring_irq
    import cmdring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en_i,
    input  logic bp_ie_i,
    input  logic ovf_ie_i,
    input  logic unf_ie_i,
    input  logic bp_i,
    input  logic ovf_i,
    input  logic unf_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       cause;

    assign cause = rd_en_i && ((bp_i && bp_ie_i) || (ovf_i && ovf_ie_i) || (unf_i && unf_ie_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (cause)  state_d = IRQ_RAISED;  // RAISE
            IRQ_RAISED: if (!cause) state_d = IRQ_QUIET;   // DROP
            default:                state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R8: read enable gates every cause
    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !irq_o);

    // R8: an enabled breakpoint with read enable raises the line next clock
    assert_bp_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && bp_i && bp_ie_i) |=> irq_o);

endmodule

// File: rtl/cmdring_ctrl.sv
module cmdring_ctrl
    import cmdring_pkg::*;
#(
    parameter int HI_BITS     = 10,
    parameter int CNT_W       = 16,
    parameter int BURST_BYTES = 32,
    localparam int AW         = LO_W + HI_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_i,
    input  logic              drain_i,
    input  logic [CNT_W-1:0]  drain_bytes_i,
    input  logic              reg_we_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [LO_W-1:0]   reg_wdata_i,
    output logic [LO_W-1:0]   reg_rdata_o,
    output logic              irq_o
);

    ctrl_t                 ctrl;
    logic [NF-1:0][AW-1:0] fld;
    logic                  ovf, unf, bp, read_idle, cmd_idle;
    logic [AW-1:0]         span;
    logic [LO_W-1:0]       rd_mux;

    cmdring_regs #(
        .HI_BITS     (HI_BITS),
        .CNT_W       (CNT_W),
        .BURST_BYTES (BURST_BYTES)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .burst_i       (burst_i),
        .drain_i       (drain_i),
        .drain_bytes_i (drain_bytes_i),
        .we_i          (reg_we_i),
        .addr_i        (reg_addr_i),
        .wdata_i       (reg_wdata_i),
        .ctrl_o        (ctrl),
        .fld_o         (fld)
    );

    cmdring_flags #(.HI_BITS(HI_BITS)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (ctrl.rd_en),
        .bp_en_i     (ctrl.bp_en),
        .dist_i      (fld[F_DIST]),
        .hiwm_i      (fld[F_HIWM]),
        .lowm_i      (fld[F_LOWM]),
        .wptr_i      (fld[F_WPTR]),
        .rptr_i      (fld[F_RPTR]),
        .bkpt_i      (fld[F_BKPT]),
        .ovf_o       (ovf),
        .unf_o       (unf),
        .bp_o        (bp),
        .read_idle_o (read_idle),
        .cmd_idle_o  (cmd_idle)
    );

    cmdring_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (ctrl.rd_en),
        .bp_ie_i  (ctrl.bp_ie),
        .ovf_ie_i (ctrl.ovf_ie),
        .unf_ie_i (ctrl.unf_ie),
        .bp_i     (bp),
        .ovf_i    (ovf),
        .unf_i    (unf),
        .irq_o    (irq_o)
    );

    always_comb begin
        if (fld[F_WPTR] >= fld[F_RPTR]) begin
            span = fld[F_WPTR] - fld[F_RPTR];
        end else begin
            span = fld[F_END] - fld[F_RPTR] + fld[F_WPTR] - fld[F_BASE] + AW'(BURST_BYTES);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr_i == A_STATUS) begin
            rd_mux = {{(LO_W-5){1'b0}}, bp, cmd_idle, read_idle, unf, ovf};
        end else if (reg_addr_i == A_CTRL) begin
            rd_mux = {{(LO_W-$bits(ctrl_t)){1'b0}}, ctrl};
        end else if (reg_addr_i == A_SPAN_LO) begin
            rd_mux = span[LO_W-1:0];
        end else if (reg_addr_i == A_SPAN_HI) begin
            rd_mux = {{(LO_W-HI_BITS){1'b0}}, span[AW-1:LO_W]};
        end
        for (int i = 0; i < NF; i++) begin
            if (reg_addr_i == lo_addr(i)) begin
                rd_mux = fld[i][LO_W-1:0];
            end else if (reg_addr_i == lo_addr(i) + 5'd1) begin
                rd_mux = {{(LO_W-HI_BITS){1'b0}}, fld[i][AW-1:LO_W]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata_o <= '0;
        end else if (reg_rd_i) begin
            reg_rdata_o <= rd_mux;
        end
    end

    // R11: a write to the status index alone leaves every field untouched
    assert_status_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == A_STATUS && !burst_i && !drain_i)
        |=> $stable(fld) && $stable(ctrl));

endmodule

// File: tb/tb_cmdring_ctrl.sv
`timescale 1ns/1ps
module tb_cmdring_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_i = 1'b0;
    logic        drain_i = 1'b0;
    logic [15:0] drain_bytes_i = '0;
    logic        reg_we_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    cmdring_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .burst_i       (burst_i),
        .drain_i       (drain_i),
        .drain_bytes_i (drain_bytes_i),
        .reg_we_i      (reg_we_i),
        .reg_rd_i      (reg_rd_i),
        .reg_addr_i    (reg_addr_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .irq_o         (irq_o)
    );

    // Monitor: compares registered read data against the scoreboard queue
    always @(posedge clk) rd_seen <= reg_rd_i;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (reg_rdata_o !== e) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", t, reg_rdata_o, e);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
        settle(3);
    endtask

    task automatic rd_expect(input logic [4:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic strobe(input logic b, input logic d, input logic [15:0] cnt);
        @(negedge clk);
        burst_i = b; drain_i = d; drain_bytes_i = cnt;
        @(negedge clk);
        burst_i = 1'b0; drain_i = 1'b0;
        settle(3);
    endtask

    task automatic irq_expect(input logic e, input string t);
        @(negedge clk);
        n_checks++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        rd_expect(5'd12, 16'h0000, "R1 write pointer low after reset");
        rd_expect(5'd1,  16'h0000, "R1 control after reset");
        rd_expect(5'd0,  16'h000C, "R1 status after reset");
        irq_expect(1'b0, "R1 interrupt after reset");

        // R10 write masks
        wr(5'd2, 16'h1234);
        rd_expect(5'd2, 16'h1220, "R10 base low alignment mask");
        wr(5'd3, 16'hFFFF);
        rd_expect(5'd3, 16'h03FF, "R10 base high width mask");
        wr(5'd3, 16'h0000);
        wr(5'd2, 16'h1000);
        wr(5'd4, 16'h1060);
        wr(5'd12, 16'h1000);
        wr(5'd14, 16'h1000);
        wr(5'd1, 16'hFFFF);
        rd_expect(5'd1, 16'h003F, "R10 control keeps six bits");

        // R2 / R4 linked bursts
        wr(5'd1, 16'h0010);
        strobe(1'b1, 1'b0, 16'd0);
        rd_expect(5'd12, 16'h1020, "R2 write pointer advances by 32");
        rd_expect(5'd10, 16'h0020, "R4 burst adds 32 to count");
        strobe(1'b1, 1'b0, 16'd0);
        strobe(1'b1, 1'b0, 16'd0);
        rd_expect(5'd12, 16'h1060, "R2 write pointer reaches end");
        strobe(1'b1, 1'b0, 16'd0);
        rd_expect(5'd12, 16'h1000, "R2 write pointer wraps to base");
        rd_expect(5'd10, 16'h0080, "R4 count after four bursts");

        // R3 unlinked burst ignored
        wr(5'd1, 16'h0000);
        strobe(1'b1, 1'b0, 16'd0);
        rd_expect(5'd12, 16'h1000, "R3 unlinked burst keeps write pointer");
        rd_expect(5'd10, 16'h0080, "R3 unlinked burst keeps count");

        // R4 drain, R5 span
        strobe(1'b0, 1'b1, 16'd64);
        rd_expect(5'd14, 16'h1040, "R4 drain advances read pointer");
        rd_expect(5'd10, 16'h0040, "R4 drain subtracts count");
        rd_expect(5'd18, 16'h0040, "R5 span with write behind read");

        // R6 / R9 status with high mark zero, read enable clear
        rd_expect(5'd0, 16'h0009, "R6 overflow and R9 command idle");

        // R8 interrupt gating
        wr(5'd1, 16'h0004);
        irq_expect(1'b0, "R8 no interrupt without read enable");
        wr(5'd1, 16'h0005);
        irq_expect(1'b1, "R8 overflow interrupt");
        rd_expect(5'd0, 16'h0001, "R9 command idle clear when reading");

        // R6 strict compares
        wr(5'd6, 16'h0040);
        irq_expect(1'b0, "R6 equal to high mark is no overflow");
        wr(5'd8, 16'h0060);
        rd_expect(5'd0, 16'h0002, "R6 underflow below low mark");
        irq_expect(1'b0, "R8 underflow not enabled");
        wr(5'd1, 16'h0009);
        irq_expect(1'b1, "R8 underflow interrupt");
        wr(5'd8, 16'h0040);
        rd_expect(5'd0, 16'h0000, "R6 equal to low mark is no underflow");
        irq_expect(1'b0, "R8 interrupt drops with cause");
        wr(5'd8, 16'h0000);

        // R7 breakpoint
        wr(5'd16, 16'h1040);
        wr(5'd1, 16'h0002);
        rd_expect(5'd0, 16'h0018, "R7 breakpoint flag at read pointer");
        wr(5'd1, 16'h0023);
        irq_expect(1'b1, "R8 breakpoint interrupt");
        rd_expect(5'd0, 16'h0018, "R9 breakpoint makes command idle");
        wr(5'd1, 16'h0021);
        rd_expect(5'd0, 16'h0000, "R7 flag forced low without enable");
        irq_expect(1'b0, "R7 no breakpoint interrupt without enable");

        // R11 status is read-only
        wr(5'd0, 16'hFFFF);
        rd_expect(5'd0, 16'h0000, "R11 status write ignored");
        rd_expect(5'd1, 16'h0021, "R11 control untouched by status write");

        // R4 read pointer wrap, R9 empty idle
        strobe(1'b0, 1'b1, 16'd32);
        strobe(1'b0, 1'b1, 16'd32);
        rd_expect(5'd14, 16'h1000, "R4 read pointer wraps to base");
        rd_expect(5'd0, 16'h000C, "R9 empty buffer reports both idle");

        // R4 simultaneous burst and drain
        wr(5'd1, 16'h0010);
        strobe(1'b1, 1'b1, 16'd32);
        rd_expect(5'd10, 16'h0000, "R4 simultaneous count");
        rd_expect(5'd12, 16'h1020, "R4 simultaneous write pointer");
        rd_expect(5'd14, 16'h1020, "R4 simultaneous read pointer");
        rd_expect(5'd18, 16'h0000, "R5 span with equal pointers");

        settle(4);
        finish_run();
    end

endmodule